// File: doc/BRIEF.md
# UART FIFO Control with Ready and Interrupt Signalling

This block holds the transmit and receive byte FIFOs of a UART together with the eight-bit control register that governs them. A host bus writes the control register, pushes bytes for transmission and pops received bytes. The serializer side pops bytes to send and pushes bytes it has received. Shift registers, baud generation and framing sit outside the block.

The control register enables both FIFOs and requests a self-clearing flush of either one. It also selects how the two active-low ready outputs and the two level interrupt requests behave. In per-character mode, they report whether a single character slot is free or filled. In block mode, they compare each FIFO fill level with a trigger level chosen from 1, 4, 8 or 14. When the FIFOs are disabled, each direction shrinks to a single holding location and behaves in per-character mode.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After synchronous reset the control register reads 0x00, both FIFOs are empty, tx_rdy_n=0, tx_irq=1, rx_rdy_n=1, rx_irq=0 and both overrun flags are 0.
- R2: A control write with bit 0 = 0 clears only bit 0 and leaves bits 7..3 unchanged. A write with bit 0 = 1 loads all eight bits.
- R3: Writing bit 1 = 1 (together with bit 0 = 1) empties the receive FIFO and clears rx_ovr on the next clock edge. Bit 1 reads 1 for exactly one cycle and then reads 0. Bit 2 does the same for the transmit FIFO and tx_ovr.
- R4: Any write that changes bit 0 flushes both FIFOs and clears both overrun flags on the following clock edge.
- R5: While bit 0 = 0, each direction holds at most one byte and follows per-character behaviour, whatever bit 3 says.
- R6: In per-character mode (bit 3 = 0, or FIFOs disabled), tx_rdy_n is 0 exactly when the transmit FIFO is empty, and rx_rdy_n is 0 exactly when the receive FIFO holds at least one byte.
- R7: In block mode (bit 0 = 1, bit 3 = 1), tx_rdy_n is 0 while at least one of the 16 transmit entries is free, and tx_irq is 1 while the transmit count is below the transmit trigger.
- R8: In block mode, rx_irq is 1 and rx_rdy_n is 0 while the receive count is at or above the receive trigger. The receive FIFO keeps accepting bytes up to 16.
- R9: Bits 5:4 select the transmit trigger and bits 7:6 select the receive trigger, with encodings 00=1, 01=4, 10=8 and 11=14. Bit 3 = 1 selects block mode.
- R10: A push into a full FIFO is dropped and sets that direction's sticky overrun flag. Accepted bytes leave in the order they were pushed.
- R11: A pop is reflected on the data output after the clock edge that takes it. A pop from an empty FIFO leaves the data output and the fill level unchanged.
- R12: In per-character mode, tx_irq is 1 while the transmit FIFO is empty, and rx_irq is 1 while the receive FIFO is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write value |
| cfg_rdata | output | 8 | Control register read-back |
| host_tx_push | input | 1 | Host pushes a byte to transmit |
| host_tx_data | input | 8 | Byte to transmit |
| ser_tx_pop | input | 1 | Serializer takes the next transmit byte |
| ser_tx_data | output | 8 | Transmit byte taken by the last pop |
| ser_rx_push | input | 1 | Serializer pushes a received byte |
| ser_rx_data | input | 8 | Received byte |
| host_rx_pop | input | 1 | Host takes the next received byte |
| host_rx_data | output | 8 | Received byte taken by the last pop |
| tx_rdy_n | output | 1 | Active-low transmit ready |
| rx_rdy_n | output | 1 | Active-low receive ready |
| tx_irq | output | 1 | Transmit interrupt request, level |
| rx_irq | output | 1 | Receive interrupt request, level |
| tx_ovr | output | 1 | Sticky transmit overrun flag |
| rx_ovr | output | 1 | Sticky receive overrun flag |

## Verification
A wrong fill count shows on the ready and interrupt outputs in the very cycle after the push or pop that corrupted it, because those outputs are decoded from the count with no extra stage. Pointer damage stays hidden until the affected entry is popped, so the tests pop every byte they push and compare the order. A self-clear bit that sticks, or a missed flush, shows as read-back bit 1 or 2 still at 1, or a ready output still asserted, one cycle after the write edge. A capacity limit that does not switch with bit 0 shows at the second push as a missing or unexpected overrun flag.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

  typedef struct packed {
    logic [1:0] rx_trig_sel;
    logic [1:0] tx_trig_sel;
    logic       block_mode;
    logic       tx_clr;
    logic       rx_clr;
    logic       fifo_en;
  } ctrl_t;

  function automatic logic [7:0] trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    trig_level = 8'd1;
      2'd1:    trig_level = 8'd4;
      2'd2:    trig_level = 8'd8;
      default: trig_level = 8'd14;
    endcase
  endfunction

endpackage

// File: rtl/ufc_ctrl_reg.sv
module ufc_ctrl_reg
  import uart_fifo_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [7:0] wdata,
  output ctrl_t      ctrl,
  output logic       rx_flush,
  output logic       tx_flush
);

  ctrl_t ctrl_q;
  logic  en_flip_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      en_flip_q <= 1'b0;
    end else begin
      ctrl_q.rx_clr <= 1'b0;
      ctrl_q.tx_clr <= 1'b0;
      en_flip_q     <= 1'b0;
      if (we) begin
        if (wdata[0]) begin
          ctrl_q    <= ctrl_t'(wdata);
          en_flip_q <= !ctrl_q.fifo_en;
        end else begin
          ctrl_q.fifo_en <= 1'b0;
          en_flip_q      <= ctrl_q.fifo_en;
        end
      end
    end
  end

  assign ctrl     = ctrl_q;
  assign rx_flush = ctrl_q.rx_clr | en_flip_q;
  assign tx_flush = ctrl_q.tx_clr | en_flip_q;

endmodule

// File: rtl/ufc_byte_fifo.sv
module ufc_byte_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              single,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  output logic [DATA_W-1:0] rdata,
  output logic [CW-1:0]     count,
  output logic              ovr
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;
  logic              full, do_push, do_pop;

  assign full    = single ? (count != '0) : (count == CW'(DEPTH));
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && (count != '0) && !flush;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (do_pop) rdata <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      ovr   <= 1'b0;
    end else begin
      if (do_push) wptr <= bump(wptr);
      if (do_pop)  rptr <= bump(rptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (push && full) ovr <= 1'b1;
    end
  end

endmodule

// File: rtl/ufc_flag_gen.sv
module ufc_flag_gen #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          block_eff,
  input  logic [1:0]    tx_sel,
  input  logic [1:0]    rx_sel,
  input  logic [CW-1:0] tx_count,
  input  logic [CW-1:0] rx_count,
  output logic          tx_rdy_n,
  output logic          rx_rdy_n,
  output logic          tx_irq,
  output logic          rx_irq
);
  import uart_fifo_pkg::*;

  logic [CW-1:0] tx_trig, rx_trig;

  assign tx_trig = CW'(trig_level(tx_sel));
  assign rx_trig = CW'(trig_level(rx_sel));

  always_comb begin
    if (block_eff) begin
      tx_rdy_n = (tx_count == CW'(DEPTH));
      tx_irq   = (tx_count < tx_trig);
      rx_rdy_n = (rx_count < rx_trig);
      rx_irq   = (rx_count >= rx_trig);
    end else begin
      tx_rdy_n = (tx_count != '0);
      tx_irq   = (tx_count == '0);
      rx_rdy_n = (rx_count == '0);
      rx_irq   = (rx_count != '0);
    end
  end

endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              host_tx_push,
  input  logic [DATA_W-1:0] host_tx_data,
  input  logic              ser_tx_pop,
  output logic [DATA_W-1:0] ser_tx_data,
  input  logic              ser_rx_push,
  input  logic [DATA_W-1:0] ser_rx_data,
  input  logic              host_rx_pop,
  output logic [DATA_W-1:0] host_rx_data,
  output logic              tx_rdy_n,
  output logic              rx_rdy_n,
  output logic              tx_irq,
  output logic              rx_irq,
  output logic              tx_ovr,
  output logic              rx_ovr
);
  import uart_fifo_pkg::*;

  localparam int CW = $clog2(DEPTH + 1);

  ctrl_t         ctrl;
  logic          rx_flush, tx_flush, single, block_eff;
  logic [CW-1:0] tx_count, rx_count;

  ufc_ctrl_reg i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .we       (cfg_we),
    .wdata    (cfg_wdata),
    .ctrl     (ctrl),
    .rx_flush (rx_flush),
    .tx_flush (tx_flush)
  );

  assign cfg_rdata = ctrl;
  assign single    = !ctrl.fifo_en;
  assign block_eff = ctrl.fifo_en && ctrl.block_mode;

  ufc_byte_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_tx_fifo (
    .clk    (clk),
    .rst    (rst),
    .flush  (tx_flush),
    .single (single),
    .push   (host_tx_push),
    .wdata  (host_tx_data),
    .pop    (ser_tx_pop),
    .rdata  (ser_tx_data),
    .count  (tx_count),
    .ovr    (tx_ovr)
  );

  ufc_byte_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_rx_fifo (
    .clk    (clk),
    .rst    (rst),
    .flush  (rx_flush),
    .single (single),
    .push   (ser_rx_push),
    .wdata  (ser_rx_data),
    .pop    (host_rx_pop),
    .rdata  (host_rx_data),
    .count  (rx_count),
    .ovr    (rx_ovr)
  );

  ufc_flag_gen #(.DEPTH(DEPTH)) i_flags (
    .block_eff (block_eff),
    .tx_sel    (ctrl.tx_trig_sel),
    .rx_sel    (ctrl.rx_trig_sel),
    .tx_count  (tx_count),
    .rx_count  (rx_count),
    .tx_rdy_n  (tx_rdy_n),
    .rx_rdy_n  (rx_rdy_n),
    .tx_irq    (tx_irq),
    .rx_irq    (rx_irq)
  );

endmodule

// File: rtl/ufc_checker.sv
module ufc_checker #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic              cfg_wd0,
  input logic [7:0]        cfg_rdata,
  input logic              host_rx_pop,
  input logic [DATA_W-1:0] host_rx_data,
  input logic              ser_rx_push,
  input logic [CW-1:0]     tx_count,
  input logic [CW-1:0]     rx_count,
  input logic              tx_rdy_n,
  input logic              rx_ovr
);

  // R2
  cfg_keep_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_we && !cfg_wd0 |=> (cfg_rdata[7:3] == $past(cfg_rdata[7:3])) && !cfg_rdata[0]);

  // R3
  rx_clear_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata[1] && !cfg_we |=> (rx_count == '0) && !cfg_rdata[1]);

  // R5
  single_cap_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_rdata[0] && $past(!cfg_rdata[0]) |-> (rx_count <= 1) && (tx_count <= 1));

  // R7
  tx_full_rdy_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata[0] && cfg_rdata[3] && (tx_count == CW'(DEPTH)) |-> tx_rdy_n);

  // R10
  rx_ovr_chk: assert property (@(posedge clk) disable iff (rst)
    ser_rx_push && (rx_count == CW'(DEPTH)) && cfg_rdata[0] && $past(cfg_rdata[0])
      && !cfg_rdata[1] |=> rx_ovr);

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_count <= CW'(DEPTH)) && (rx_count <= CW'(DEPTH)));

  // R11
  pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
    host_rx_pop && (rx_count == '0) |=> $stable(host_rx_data));

endmodule

bind uart_fifo_ctrl ufc_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_we       (cfg_we),
  .cfg_wd0      (cfg_wdata[0]),
  .cfg_rdata    (cfg_rdata),
  .host_rx_pop  (host_rx_pop),
  .host_rx_data (host_rx_data),
  .ser_rx_push  (ser_rx_push),
  .tx_count     (tx_count),
  .rx_count     (rx_count),
  .tx_rdy_n     (tx_rdy_n),
  .rx_ovr       (rx_ovr)
);

// File: tb/test_uart_fifo_ctrl.sv
module test_uart_fifo_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       host_tx_push = 1'b0;
  logic [7:0] host_tx_data = '0;
  logic       ser_tx_pop = 1'b0;
  logic [7:0] ser_tx_data;
  logic       ser_rx_push = 1'b0;
  logic [7:0] ser_rx_data = '0;
  logic       host_rx_pop = 1'b0;
  logic [7:0] host_rx_data;
  logic       tx_rdy_n, rx_rdy_n, tx_irq, rx_irq, tx_ovr, rx_ovr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = !clk;

  uart_fifo_ctrl i_uart_fifo_ctrl (
    .clk, .rst, .cfg_we, .cfg_wdata, .cfg_rdata,
    .host_tx_push, .host_tx_data, .ser_tx_pop, .ser_tx_data,
    .ser_rx_push, .ser_rx_data, .host_rx_pop, .host_rx_data,
    .tx_rdy_n, .rx_rdy_n, .tx_irq, .rx_irq, .tx_ovr, .rx_ovr
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_write(input logic [7:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic tx_push(input logic [7:0] d);
    @(negedge clk); host_tx_push = 1'b1; host_tx_data = d;
    @(negedge clk); host_tx_push = 1'b0;
  endtask

  task automatic tx_pop();
    @(negedge clk); ser_tx_pop = 1'b1;
    @(negedge clk); ser_tx_pop = 1'b0;
  endtask

  task automatic rx_push(input logic [7:0] d);
    @(negedge clk); ser_rx_push = 1'b1; ser_rx_data = d;
    @(negedge clk); ser_rx_push = 1'b0;
  endtask

  task automatic rx_pop();
    @(negedge clk); host_rx_pop = 1'b1;
    @(negedge clk); host_rx_pop = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 cfg", cfg_rdata, 8'h00);
    check("R1 tx_rdy_n", tx_rdy_n, 0);
    check("R1 tx_irq", tx_irq, 1);
    check("R1 rx_rdy_n", rx_rdy_n, 1);
    check("R1 rx_irq", rx_irq, 0);
    check("R1 ovr", {tx_ovr, rx_ovr}, 0);
  endtask

  task automatic t_disabled();
    rx_push(8'hA5);
    check("R6 rx_rdy_n one byte", rx_rdy_n, 0);
    check("R12 rx_irq one byte", rx_irq, 1);
    rx_push(8'h3C);
    check("R5 rx second push overruns", rx_ovr, 1);
    rx_pop();
    check("R10 rx data kept", host_rx_data, 8'hA5);
    check("R5 rx empty after one pop", rx_rdy_n, 1);
    rx_pop();
    check("R11 pop empty keeps data", host_rx_data, 8'hA5);
    check("R11 pop empty keeps level", rx_irq, 0);
    tx_push(8'h11);
    check("R6 tx_rdy_n occupied", tx_rdy_n, 1);
    check("R12 tx_irq occupied", tx_irq, 0);
    tx_push(8'h22);
    check("R5 tx second push overruns", tx_ovr, 1);
    tx_pop();
    check("R11 tx pop data", ser_tx_data, 8'h11);
    check("R6 tx_rdy_n empty", tx_rdy_n, 0);
    check("R5 block bit ignored while disabled", {tx_ovr, rx_ovr}, 2'b11);
  endtask

  task automatic t_flush();
    rx_push(8'h77);
    cfg_write(8'h01);
    idle(1);
    check("R4 flush clears ovr", {tx_ovr, rx_ovr}, 0);
    check("R4 flush empties rx", rx_rdy_n, 1);
    check("R2 full load", cfg_rdata, 8'h01);
  endtask

  task automatic t_mode0_fifo();
    tx_push(8'h01); tx_push(8'h02); tx_push(8'h03);
    check("R6 tx_rdy_n with three", tx_rdy_n, 1);
    check("R5 enabled holds more than one", tx_ovr, 0);
    tx_pop(); check("R10 order 1", ser_tx_data, 8'h01);
    tx_pop(); check("R10 order 2", ser_tx_data, 8'h02);
    check("R6 tx_rdy_n still busy", tx_rdy_n, 1);
    tx_pop(); check("R10 order 3", ser_tx_data, 8'h03);
    check("R6 tx_rdy_n empty again", tx_rdy_n, 0);
  endtask

  task automatic t_block_tx();
    for (int sel = 0; sel < 4; sel++) begin
      int trig;
      trig = (sel == 0) ? 1 : (sel == 1) ? 4 : (sel == 2) ? 8 : 14;
      cfg_write(8'h09 | 8'(sel << 4));
      check("R9 tx sel readback", cfg_rdata, 8'h09 | (sel << 4));
      for (int i = 0; i < trig - 1; i++) tx_push(8'(i));
      check("R7 tx_irq below trig", tx_irq, 1);
      tx_push(8'hEE);
      check("R7 R9 tx_irq at trig", tx_irq, 0);
      check("R7 tx_rdy_n free room", tx_rdy_n, 0);
      cfg_write(8'h0D | 8'(sel << 4));
      idle(1);
      check("R3 tx clear bit self-clears", cfg_rdata[2], 0);
    end
    for (int i = 0; i < 15; i++) tx_push(8'(i + 8'h40));
    check("R7 tx_rdy_n at 15", tx_rdy_n, 0);
    tx_push(8'h4F);
    check("R7 tx_rdy_n at 16", tx_rdy_n, 1);
    tx_push(8'h99);
    check("R10 tx ovr on full", tx_ovr, 1);
    tx_pop();
    check("R10 tx first out", ser_tx_data, 8'h40);
    cfg_write(8'h0D);
    check("R3 tx clear bit reads 1", cfg_rdata[2], 1);
    idle(1);
    check("R3 tx clear bit reads 0", cfg_rdata[2], 0);
    check("R3 tx ovr cleared", tx_ovr, 0);
    check("R3 tx empty", tx_irq, 1);
  endtask

  task automatic t_block_rx();
    for (int sel = 0; sel < 4; sel++) begin
      int trig;
      trig = (sel == 0) ? 1 : (sel == 1) ? 4 : (sel == 2) ? 8 : 14;
      cfg_write(8'h09 | 8'(sel << 6));
      for (int i = 0; i < trig - 1; i++) rx_push(8'(i));
      check("R8 rx_irq below trig", rx_irq, 0);
      check("R8 rx_rdy_n below trig", rx_rdy_n, 1);
      rx_push(8'hDD);
      check("R8 R9 rx_irq at trig", rx_irq, 1);
      check("R8 rx_rdy_n at trig", rx_rdy_n, 0);
      cfg_write(8'h0B | 8'(sel << 6));
      check("R3 rx clear bit reads 1", cfg_rdata[1], 1);
      idle(1);
      check("R3 rx clear empties", rx_irq, 0);
    end
    cfg_write(8'hC9);
    for (int i = 0; i < 16; i++) rx_push(8'(i + 8'h80));
    check("R8 accepts past trig to 16", rx_ovr, 0);
    rx_push(8'h55);
    check("R10 rx ovr on full", rx_ovr, 1);
    for (int i = 0; i < 16; i++) begin
      rx_pop();
      check("R10 rx order", host_rx_data, i + 8'h80);
    end
    check("R8 rx below trig after drain", rx_rdy_n, 1);
  endtask

  task automatic t_disable_write();
    cfg_write(8'hF9);
    rx_push(8'h12);
    cfg_write(8'h00);
    check("R2 bit0 clear keeps upper", cfg_rdata, 8'hF8);
    idle(1);
    check("R4 disable flushes rx", rx_rdy_n, 1);
    rx_push(8'h34);
    check("R5 per-char rx after disable", rx_rdy_n, 0);
    rx_push(8'h35);
    check("R5 single cap after disable", rx_ovr, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_disabled();
    t_flush();
    t_mode0_fifo();
    t_block_tx();
    t_block_rx();
    t_disable_write();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule